// File: doc/BRIEF.md
# Iterative Unsigned Long Divider

This block divides an unsigned double-width dividend by a single-width divisor and returns a single-width quotient and remainder. It is the arithmetic engine behind a stack machine's divide-with-remainder primitive. The dividend arrives as a high half and a low half, together with the divisor and a one-cycle start pulse. The unit then runs one restoring step per clock. A step shifts the concatenated high:low register pair left by one bit. It compares the widened partial remainder against the divisor, and where the divisor fits it subtracts and sets the freed low bit.

After `DW` steps the high register holds the remainder and the low register holds the quotient. Both are presented directly on the outputs and held until the next accepted start. Requests whose quotient cannot fit in `DW` bits are flagged as overflow at the time of the request, and no step is spent on them. A divisor of zero is one such request.

Top module: `udiv_iter`

## Requirements
- R1: After reset, `busy_o`, `done_o` and `overflow_o` are 0, and `quotient_o` and `remainder_o` are 0.
- R2: A `start_i` sampled while idle and without overflow makes `busy_o` read 1 from the following cycle onward.
- R3: When `divisor_i <= dividend_hi_i` at an accepted start (this includes a divisor of 0), `overflow_o` reads 1 and `done_o` pulses in the very next cycle, while `busy_o` stays 0.
- R4: A non-overflowing division completes in exactly `DW` steps. `done_o` reads 1 in the `DW`-th cycle after `busy_o` first reads 1, and in that same cycle `busy_o` reads 0.
- R5: On completion without overflow, quotient*divisor + remainder equals `{dividend_hi_i, dividend_lo_i}`, and the remainder is less than the divisor.
- R6: The bit shifted out of the top of the partial remainder takes part in the compare. For example, 0xFFFE_FFFF / 0xFFFF gives quotient 0xFFFF and remainder 0xFFFE.
- R7: `done_o` is high for a single cycle. `quotient_o`, `remainder_o` and `overflow_o` hold their values until the next accepted start.
- R8: A `start_i` pulse while `busy_o` is 1 is ignored, and the running division returns the result of its own operands.
- R9: Known cases: 0x87 / 0xD gives quotient 0xA and remainder 0x5, and 0xBC2F / 0xEE gives quotient 0xCA and remainder 0x63. The first case also holds for `DW` = 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request pulse; sampled only when idle |
| dividend_hi_i | input | DW | Upper half of the dividend |
| dividend_lo_i | input | DW | Lower half of the dividend |
| divisor_i | input | DW | Divisor |
| busy_o | output | 1 | Division in progress |
| done_o | output | 1 | One-cycle completion pulse |
| quotient_o | output | DW | Quotient (low register) |
| remainder_o | output | DW | Remainder (high register) |
| overflow_o | output | 1 | Quotient would not fit; result not valid |

## Verification
The bench builds two copies of the block. The first uses the default `DW` = 16 and covers the table of known vectors, the carry-out case, overflow on equal, larger and zero divisors, and a few hundred random non-overflowing requests checked against the division identity. The second uses `DW` = 4, which is small enough to sweep every high half, low half and divisor combination. That sweep exercises every overflow boundary and every step count with a 4-step run.

// File: rtl/udiv_pkg.sv
package udiv_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } udiv_state_e;

  function automatic int unsigned cnt_width(int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/udiv_step.sv
// One restoring step: shift {t,n} left, compare on DW+1 bits, subtract if fits.
module udiv_step #(
  parameter int unsigned DW = 16
) (
  input  logic [DW-1:0] t_i,
  input  logic [DW-1:0] n_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] t_o,
  output logic [DW-1:0] n_o
);

  localparam int unsigned EW = DW + 1;

  logic [EW-1:0] ext;
  logic [EW-1:0] dext;
  logic          fits;

  assign ext  = {t_i, n_i[DW-1]};
  assign dext = {1'b0, d_i};
  assign fits = (ext >= dext);

  always_comb begin
    if (fits) t_o = DW'(ext - dext);
    else      t_o = ext[DW-1:0];
    n_o = {n_i[DW-2:0], fits};
  end

endmodule

// File: rtl/udiv_ctrl.sv
module udiv_ctrl
  import udiv_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic ovf_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);

  localparam int unsigned    CW   = cnt_width(DW);
  localparam logic [CW-1:0]  LAST = CW'(DW - 1);

  udiv_state_e   state_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  assign load_o = start_i && (state_q == ST_IDLE);
  assign step_o = (state_q == ST_RUN);
  assign busy_o = (state_q == ST_RUN);
  assign done_o = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            cnt_q <= '0;
            if (ovf_i) done_q  <= 1'b1;
            else       state_q <= ST_RUN;
          end
        end
        ST_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R2: accepted clean start enters run
  p_busy_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o && !ovf_i) |=> busy_o);

  // R4: run continues until the last step
  p_run_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && cnt_q != LAST) |=> step_o);

  // R4: last step ends run with done
  p_last_done_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && cnt_q == LAST) |=> (done_o && !busy_o));

  // R7: done is a single-cycle pulse unless a new start is accepted
  p_done_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> !done_o);

endmodule

// File: rtl/udiv_iter.sv
module udiv_iter #(
  parameter int unsigned DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] dividend_hi_i,
  input  logic [DW-1:0] dividend_lo_i,
  input  logic [DW-1:0] divisor_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] quotient_o,
  output logic [DW-1:0] remainder_o,
  output logic          overflow_o
);

  logic [DW-1:0] t_q, n_q, n2_q;
  logic [DW-1:0] t_nxt, n_nxt;
  logic          ovf_req;
  logic          load, step;
  logic          ovf_q;

  // divisor 0 is covered: 0 <= any high half
  assign ovf_req = (divisor_i <= dividend_hi_i);

  udiv_ctrl #(.DW(DW)) u_ctrl (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start_i),
    .ovf_i  (ovf_req),
    .load_o (load),
    .step_o (step),
    .busy_o (busy_o),
    .done_o (done_o)
  );

  udiv_step #(.DW(DW)) u_step (
    .t_i(t_q),
    .n_i(n_q),
    .d_i(n2_q),
    .t_o(t_nxt),
    .n_o(n_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      t_q   <= '0;
      n_q   <= '0;
      n2_q  <= '0;
      ovf_q <= 1'b0;
    end else if (load) begin
      t_q   <= dividend_hi_i;
      n_q   <= dividend_lo_i;
      n2_q  <= divisor_i;
      ovf_q <= ovf_req;
    end else if (step) begin
      t_q <= t_nxt;
      n_q <= n_nxt;
    end
  end

  assign quotient_o  = n_q;
  assign remainder_o = t_q;
  assign overflow_o  = ovf_q;

  // R3: an overflowed request never runs
  p_no_overflow_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o |-> !busy_o);

  // R5: partial remainder stays below the divisor while running
  p_rem_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (t_q < n2_q));

  // R8: operands are frozen while running
  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> $stable(n2_q));

  // R7: results hold while idle with no start
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(quotient_o) && $stable(remainder_o) && $stable(overflow_o)));

endmodule

// File: tb/udiv_iter_tb_top.sv
`timescale 1ns/1ps
module udiv_iter_tb_top;

  localparam int unsigned DW  = 16;
  localparam int unsigned SDW = 4;
  localparam int unsigned NV  = 8;

  // {hi, lo, divisor, quotient, remainder}
  localparam logic [79:0] VEC [NV] = '{
    {16'h0000, 16'h0087, 16'h000D, 16'h000A, 16'h0005},
    {16'h0000, 16'hBC2F, 16'h00EE, 16'h00CA, 16'h0063},
    {16'hFFFE, 16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFE},
    {16'h0000, 16'h0000, 16'h0001, 16'h0000, 16'h0000},
    {16'h0000, 16'hFFFF, 16'h0001, 16'hFFFF, 16'h0000},
    {16'h1234, 16'h5678, 16'h8000, 16'h2468, 16'h5678},
    {16'h0007, 16'h0000, 16'h0008, 16'hE000, 16'h0000},
    {16'h0000, 16'h0064, 16'h0007, 16'h000E, 16'h0002}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          start = 1'b0;
  logic [DW-1:0] hi = '0, lo = '0, dv = '0;
  logic          busy, done, ovf;
  logic [DW-1:0] quo, rem;

  logic           s_start = 1'b0;
  logic [SDW-1:0] s_hi = '0, s_lo = '0, s_dv = '0;
  logic           s_busy, s_done, s_ovf;
  logic [SDW-1:0] s_quo, s_rem;

  int tests = 0;
  int fails = 0;

  udiv_iter #(.DW(DW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start),
    .dividend_hi_i(hi), .dividend_lo_i(lo), .divisor_i(dv),
    .busy_o(busy), .done_o(done), .quotient_o(quo),
    .remainder_o(rem), .overflow_o(ovf)
  );

  udiv_iter #(.DW(SDW)) dut_small_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(s_start),
    .dividend_hi_i(s_hi), .dividend_lo_i(s_lo), .divisor_i(s_dv),
    .busy_o(s_busy), .done_o(s_done), .quotient_o(s_quo),
    .remainder_o(s_rem), .overflow_o(s_ovf)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Runs one division on the 16-bit instance; returns cycles from start to done.
  task automatic run16(input logic [DW-1:0] h, input logic [DW-1:0] l,
                       input logic [DW-1:0] d, output int cyc, output logic b1);
    @(negedge clk);
    hi = h; lo = l; dv = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cyc = 1;
    b1  = busy;
    while (!done && cyc < 60) begin
      @(negedge clk);
      cyc++;
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int cyc;
    logic b1;
    logic [63:0] prod;

    repeat (3) @(negedge clk);
    // R1: reset state
    check(!busy && !done && !ovf, "R1", "flags after reset", {busy, done, ovf}, 0);
    check(quo == 0 && rem == 0, "R1", "results after reset", {quo, rem}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 / R5 / R6: vector table
    for (int i = 0; i < NV; i++) begin
      run16(VEC[i][79:64], VEC[i][63:48], VEC[i][47:32], cyc, b1);
      check(b1, "R2", "busy after start", b1, 1);
      check(cyc == DW + 1 && !busy, "R4", "cycles to done", cyc, DW + 1);
      check(!ovf, "R3", "no overflow on vector", ovf, 0);
      check(quo == VEC[i][31:16], (i == 2) ? "R6" : "R9", "quotient", quo, VEC[i][31:16]);
      check(rem == VEC[i][15:0],  (i == 2) ? "R6" : "R9", "remainder", rem, VEC[i][15:0]);
      @(negedge clk);
      check(!done, "R7", "done single pulse", done, 0);
      check(quo == VEC[i][31:16] && rem == VEC[i][15:0], "R7", "results held",
            {quo, rem}, {VEC[i][31:16], VEC[i][15:0]});
    end

    // R5: random non-overflowing divisions
    for (int i = 0; i < 300; i++) begin
      logic [DW-1:0] d, h, l;
      d = DW'($urandom);
      if (d == 0) d = 1;
      h = DW'($urandom) % d;
      l = DW'($urandom);
      run16(h, l, d, cyc, b1);
      prod = 64'(quo) * 64'(d) + 64'(rem);
      check(!ovf && prod == {32'h0, h, l}, "R5", "q*d+r", prod, {32'h0, h, l});
      check(rem < d, "R5", "remainder below divisor", rem, d);
    end

    // R3: overflow cases (equal, larger, zero divisor)
    run16(16'h0010, 16'h1234, 16'h0010, cyc, b1);
    check(ovf && cyc == 1 && !b1, "R3", "divisor equal to high half", {ovf, cyc[7:0]}, {1'b1, 8'd1});
    run16(16'h8000, 16'h0000, 16'h0123, cyc, b1);
    check(ovf && cyc == 1 && !b1, "R3", "divisor below high half", {ovf, cyc[7:0]}, {1'b1, 8'd1});
    run16(16'h0000, 16'h0005, 16'h0000, cyc, b1);
    check(ovf && cyc == 1 && !b1, "R3", "divisor zero", {ovf, cyc[7:0]}, {1'b1, 8'd1});
    repeat (3) @(negedge clk);
    check(ovf && !busy && !done, "R7", "overflow held", {ovf, busy, done}, 3'b100);

    // R8: start while busy ignored
    @(negedge clk);
    hi = 16'h0000; lo = 16'h0087; dv = 16'h000D; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    hi = 16'h0001; lo = 16'hFFFF; dv = 16'h0003; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check(quo == 16'h000A && rem == 16'h0005 && !ovf, "R8", "result of first request",
          {quo, rem}, {16'h000A, 16'h0005});
    @(negedge clk);
    check(!busy && !done, "R8", "no second run", {busy, done}, 0);

    // R9 / R3 / R5: exhaustive sweep on DW=4
    for (int h = 0; h < 16; h++) begin
      for (int l = 0; l < 16; l++) begin
        for (int d = 0; d < 16; d++) begin
          int sc;
          int numer;
          @(negedge clk);
          s_hi = SDW'(h); s_lo = SDW'(l); s_dv = SDW'(d); s_start = 1'b1;
          @(negedge clk);
          s_start = 1'b0;
          sc = 1;
          while (!s_done && sc < 20) begin
            @(negedge clk);
            sc++;
          end
          numer = h * 16 + l;
          if (d <= h) begin
            check(s_ovf && sc == 1, "R3", "small overflow", {s_ovf, sc[7:0]}, {1'b1, 8'd1});
          end else begin
            check(!s_ovf && sc == SDW + 1, "R4", "small cycles", sc, SDW + 1);
            check(s_quo == SDW'(numer / d) && s_rem == SDW'(numer % d),
                  (numer == 135 && d == 13) ? "R9" : "R5", "small result",
                  {s_quo, s_rem}, {SDW'(numer / d), SDW'(numer % d)});
          end
        end
      end
    end

    // R1: reset during a run
    @(negedge clk);
    hi = 16'h0000; lo = 16'h4321; dv = 16'h0011; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(!busy && !done && !ovf && quo == 0 && rem == 0, "R1", "reset mid-run",
          {busy, done, ovf, quo, rem}, 0);
    rst_n = 1'b1;

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule